// File: doc/BRIEF.md
# Interleaved Multi-Bank Memory Scheduler

This block sits between a single requester and a set of independent memory banks. Each request carries a byte-range address, a read/write flag and write data. The block splits the address into a bank index and an in-bank offset, then sends the request to that bank. A build-time mode chooses the split. In low-order interleaving, consecutive addresses fall in consecutive banks. In high-order banking, each bank owns one contiguous slice of the address space.

Every bank runs its own timer. A bank accepts a new access only after its full cycle time has passed since its previous one. Accesses to different banks overlap freely. A request whose target bank is still busy holds `req_ready` low until that bank frees. Read data comes back a fixed access time after the request is accepted, tagged with the bank index. Because that latency is fixed and the block accepts at most one request per cycle, responses leave in the order the requests were accepted. Writes update the bank and return no response.

The bank storage is a behavioural model. Only the low `STORE_W` bits of the in-bank offset index it, so offsets that differ only above those bits share one entry.

Top module: `ilv_bank_sched`

## Requirements
- R1: With `MAP_MODE = MAP_LOW`, the bank index is `addr[BSEL_W-1:0]` and the in-bank offset is `addr[ADDR_W-1:BSEL_W]`, where `BSEL_W = log2(NUM_BANKS)`.
- R2: With `MAP_MODE = MAP_HIGH`, the bank index is `addr[ADDR_W-1:ADDR_W-BSEL_W]` and the in-bank offset is `addr[ADDR_W-BSEL_W-1:0]`.
- R3: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` depends only on whether the bank addressed by `req_addr` is busy; other banks being busy has no effect on it.
- R4: After a bank accepts a request, it refuses new requests for exactly `CYCLE_CYC` clock cycles. If the next request to that bank is presented at once, `req_ready` stays low for `CYCLE_CYC-1` cycles, and the request is accepted on the `CYCLE_CYC`-th edge after the first.
- R5: Requests to distinct free banks are accepted on consecutive edges. In particular, `NUM_BANKS` sequential addresses in low-order mode are accepted with no stall.
- R6: A read accepted on edge k raises `rsp_valid` for one cycle, so that `rsp_valid` is sampled high on edge k+`ACCESS_CYC`. `rsp_bank` carries the bank index and `rsp_data` carries the most recent data written to that bank entry.
- R7: Read responses leave in the order the reads were accepted, one per cycle for back-to-back reads.
- R8: A write stores `req_wdata` in the addressed bank entry and produces no response.
- R9: After reset, all banks are free, `rsp_valid` is low and every stored entry reads as zero.
- R10: With `NUM_BANKS = 8`, the bank index is `addr[2:0]`, and an address that returns to a bank exactly `CYCLE_CYC` requests later is accepted without a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Target bank can accept the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte-range request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response present for one cycle |
| rsp_bank | output | BSEL_W | Bank index of the response |
| rsp_data | output | DATA_W | Read data |

## Verification
The bench targets the exact edge on which a busy bank becomes free. A timer that is off by one either stalls a sequence of strictly interleaved requests (visible in the 8-bank run) or accepts a repeat access one cycle early (visible as a stall count other than `CYCLE_CYC-1`). It issues the same nearby addresses in both mapping modes. Taking the bank field from the wrong end of the address turns a stall-free stream into a stalled one, or returns the wrong `rsp_bank` and data. It also checks the response edge, the bank tags, the order of back-to-back reads and the absence of responses after writes. A response-path design with the wrong depth, a lost tag or a write that emits a response fails these checks.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
   typedef enum logic {
      MAP_LOW  = 1'b0,
      MAP_HIGH = 1'b1
   } map_e;
endpackage

// File: rtl/ilv_addr_split.sv
module ilv_addr_split #(
   parameter int          ADDR_W   = 26,
   parameter int          BSEL_W   = 4,
   parameter ilv_pkg::map_e MAP_MODE = ilv_pkg::MAP_LOW,
   localparam int         OFF_W    = ADDR_W - BSEL_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [BSEL_W-1:0] bank,
   output logic [OFF_W-1:0]  offset
);
   generate
      if (MAP_MODE == ilv_pkg::MAP_LOW) begin : g_low
         // R1: the lowest bits pick the bank
         assign bank   = addr[BSEL_W-1:0];
         assign offset = addr[ADDR_W-1:BSEL_W];
      end else begin : g_high
         // R2: the top bits pick the bank
         assign bank   = addr[ADDR_W-1:OFF_W];
         assign offset = addr[OFF_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/ilv_bank_timer.sv
module ilv_bank_timer #(
   parameter int  CYCLE_CYC = 8,
   localparam int CYC_W     = (CYCLE_CYC < 2) ? 1 : $clog2(CYCLE_CYC)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   output logic busy
);
   logic [CYC_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (issue) begin
         remain <= CYC_W'(CYCLE_CYC - 1);
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign busy = (remain != '0);

   // R4: the scheduler never starts an access on a bank that is still cycling
   p_no_issue_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue && busy));

   // R4: each access reserves the bank for the full cycle time
   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> (remain == CYC_W'(CYCLE_CYC - 1)));

   // R4: the reservation shrinks by one every idle cycle
   p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !issue) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/ilv_bank_store.sv
module ilv_bank_store #(
   parameter int  NUM_BANKS = 16,
   parameter int  STORE_W   = 4,
   parameter int  DATA_W    = 32,
   localparam int BSEL_W    = $clog2(NUM_BANKS),
   localparam int ENTRIES   = 1 << STORE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BSEL_W-1:0] bank,
   input  logic [STORE_W-1:0] idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] cells [NUM_BANKS][ENTRIES];

   // R8, R9: write on acceptance, cleared at reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NUM_BANKS; b++) begin
            for (int e = 0; e < ENTRIES; e++) begin
               cells[b][e] <= '0;
            end
         end
      end else if (wr_en) begin
         cells[bank][idx] <= wdata;
      end
   end

   assign rdata = cells[bank][idx];
endmodule

// File: rtl/ilv_resp_pipe.sv
module ilv_resp_pipe #(
   parameter int  ACCESS_CYC = 4,
   parameter int  DATA_W     = 32,
   parameter int  BSEL_W     = 4,
   localparam int PEND_W     = $clog2(ACCESS_CYC + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [BSEL_W-1:0] push_bank,
   input  logic [DATA_W-1:0] push_data,
   output logic              rsp_valid,
   output logic [BSEL_W-1:0] rsp_bank,
   output logic [DATA_W-1:0] rsp_data
);
   logic              st_vld  [ACCESS_CYC];
   logic [BSEL_W-1:0] st_bank [ACCESS_CYC];
   logic [DATA_W-1:0] st_data [ACCESS_CYC];

   // Fixed-depth delay line: equal latency keeps responses in order (R7)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ACCESS_CYC; i++) begin
            st_vld[i]  <= 1'b0;
            st_bank[i] <= '0;
            st_data[i] <= '0;
         end
      end else begin
         st_vld[0]  <= push;
         st_bank[0] <= push_bank;
         st_data[0] <= push_data;
         for (int i = 1; i < ACCESS_CYC; i++) begin
            st_vld[i]  <= st_vld[i-1];
            st_bank[i] <= st_bank[i-1];
            st_data[i] <= st_data[i-1];
         end
      end
   end

   assign rsp_valid = st_vld[ACCESS_CYC-1];
   assign rsp_bank  = st_bank[ACCESS_CYC-1];
   assign rsp_data  = st_data[ACCESS_CYC-1];

   // Outstanding-read count, used to guard the response path
   logic [PEND_W-1:0] pend;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
      end else begin
         pend <= pend + PEND_W'(push) - PEND_W'(rsp_valid);
      end
   end

   // R7: no response without an accepted read behind it
   p_rsp_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (pend != '0));

   // R6: outstanding reads never exceed the pipeline depth
   p_pend_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pend <= PEND_W'(ACCESS_CYC));
endmodule

// File: rtl/ilv_bank_sched.sv
module ilv_bank_sched #(
   parameter int            ADDR_W     = 26,
   parameter int            DATA_W     = 32,
   parameter int            NUM_BANKS  = 16,
   parameter ilv_pkg::map_e MAP_MODE   = ilv_pkg::MAP_LOW,
   parameter int            ACCESS_CYC = 4,
   parameter int            CYCLE_CYC  = 8,
   parameter int            STORE_W    = 4,
   localparam int           BSEL_W     = $clog2(NUM_BANKS),
   localparam int           OFF_W      = ADDR_W - BSEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [BSEL_W-1:0] rsp_bank,
   output logic [DATA_W-1:0] rsp_data
);
   // Elaboration-time parameter checks
   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (ACCESS_CYC < 1) begin : g_bad_access
         $error("ACCESS_CYC must be at least 1");
      end
      if (CYCLE_CYC < ACCESS_CYC) begin : g_bad_cycle
         $error("CYCLE_CYC must not be shorter than ACCESS_CYC");
      end
      if (STORE_W < 1 || STORE_W > OFF_W) begin : g_bad_store
         $error("STORE_W must lie between 1 and the in-bank offset width");
      end
   endgenerate

   logic [BSEL_W-1:0] tgt_bank;
   logic [OFF_W-1:0]  tgt_off;
   logic [NUM_BANKS-1:0] bank_busy;
   logic [DATA_W-1:0] rd_word;
   logic              accept;

   ilv_addr_split #(
      .ADDR_W   (ADDR_W),
      .BSEL_W   (BSEL_W),
      .MAP_MODE (MAP_MODE)
   ) u_split (
      .addr   (req_addr),
      .bank   (tgt_bank),
      .offset (tgt_off)
   );

   // R3: readiness follows only the addressed bank
   assign req_ready = !bank_busy[tgt_bank];
   assign accept    = req_valid && req_ready;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         ilv_bank_timer #(
            .CYCLE_CYC (CYCLE_CYC)
         ) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .issue (accept && (tgt_bank == BSEL_W'(b))),
            .busy  (bank_busy[b])
         );
      end
      if (OFF_W > STORE_W) begin : g_off_unused
         logic unused_off_hi;
         assign unused_off_hi = ^tgt_off[OFF_W-1:STORE_W];
      end
   endgenerate

   ilv_bank_store #(
      .NUM_BANKS (NUM_BANKS),
      .STORE_W   (STORE_W),
      .DATA_W    (DATA_W)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (accept && req_write),
      .bank  (tgt_bank),
      .idx   (tgt_off[STORE_W-1:0]),
      .wdata (req_wdata),
      .rdata (rd_word)
   );

   ilv_resp_pipe #(
      .ACCESS_CYC (ACCESS_CYC),
      .DATA_W     (DATA_W),
      .BSEL_W     (BSEL_W)
   ) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (accept && !req_write),
      .push_bank (tgt_bank),
      .push_data (rd_word),
      .rsp_valid (rsp_valid),
      .rsp_bank  (rsp_bank),
      .rsp_data  (rsp_data)
   );

   generate
      if (CYCLE_CYC > 1) begin : g_chk_repeat
         // R4: the bank just used cannot accept again on the next edge
         p_same_bank_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
            accept |=> !(req_valid && req_ready && tgt_bank == $past(tgt_bank)));
      end
   endgenerate

   // R9: reset leaves every bank free
   p_reset_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (bank_busy == '0));
endmodule

// File: tb/test_ilv_bank_sched.sv
module test_ilv_bank_sched;
   localparam int ACC = 4;
   localparam int CYC = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_write = 1'b0;
   logic [25:0] req_addr = '0;
   logic [31:0] req_wdata = '0;

   logic rdy_lo, rdy_hi, rdy_w8;
   logic rv_lo, rv_hi, rv_w8;
   logic [3:0] rb_lo, rb_hi;
   logic [2:0] rb_w8;
   logic [31:0] rd_lo, rd_hi, rd_w8;

   int n_checks = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   ilv_bank_sched #(.MAP_MODE(ilv_pkg::MAP_LOW), .ACCESS_CYC(ACC), .CYCLE_CYC(CYC)) i_ilv_bank_sched (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_lo), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_lo), .rsp_bank(rb_lo), .rsp_data(rd_lo));

   ilv_bank_sched #(.MAP_MODE(ilv_pkg::MAP_HIGH), .ACCESS_CYC(ACC), .CYCLE_CYC(CYC)) i_ilv_bank_sched_hi (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_hi), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_hi), .rsp_bank(rb_hi), .rsp_data(rd_hi));

   ilv_bank_sched #(.NUM_BANKS(8), .ACCESS_CYC(ACC), .CYCLE_CYC(CYC)) i_ilv_bank_sched_w8 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_w8), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_w8), .rsp_bank(rb_w8), .rsp_data(rd_w8));

   function automatic logic rdy_of(input int u);
      return (u == 0) ? rdy_lo : (u == 1) ? rdy_hi : rdy_w8;
   endfunction
   function automatic logic rv_of(input int u);
      return (u == 0) ? rv_lo : (u == 1) ? rv_hi : rv_w8;
   endfunction
   function automatic logic [3:0] rb_of(input int u);
      return (u == 0) ? rb_lo : (u == 1) ? rb_hi : {1'b0, rb_w8};
   endfunction
   function automatic logic [31:0] rd_of(input int u);
      return (u == 0) ? rd_lo : (u == 1) ? rd_hi : rd_w8;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      req_valid = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Presents one request from just after a falling edge; returns the stall count.
   task automatic issue(input int u, input bit wr, input logic [25:0] a, input logic [31:0] d,
                        output int stalls);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      stalls = 0;
      #1;
      while (!rdy_of(u) && stalls < 50) begin
         @(negedge clk); #1;
         stalls++;
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic read_expect(input int u, input logic [25:0] a, input logic [3:0] bank,
                              input logic [31:0] data, input string req);
      int st;
      issue(u, 1'b0, a, '0, st);
      repeat (ACC - 2) @(negedge clk);
      #1 check(rv_of(u) == 1'b0, "R6 early response", rv_of(u), 0);
      @(negedge clk);
      #1;
      check(rv_of(u) == 1'b1, "R6 response edge", rv_of(u), 1);
      check(rb_of(u) == bank, {req, " bank tag"}, rb_of(u), bank);
      check(rd_of(u) == data, {req, " data"}, rd_of(u), data);
   endtask

   task automatic t_reset_r9();
      do_reset();
      #1;
      check(rv_lo == 1'b0 && rv_hi == 1'b0 && rv_w8 == 1'b0, "R9 rsp_valid after reset", rv_lo, 0);
      req_addr = 26'h0000007;
      #1 check(rdy_lo && rdy_hi && rdy_w8, "R9 ready after reset", {rdy_lo, rdy_hi, rdy_w8}, 3'b111);
      @(negedge clk);
      read_expect(0, 26'h0000027, 4'd7, 32'h0, "R9 unwritten entry");
   endtask

   task automatic t_low_stream_r5();
      int st;
      int worst = 0;
      do_reset();
      for (int i = 0; i < 16; i++) begin
         issue(0, 1'b1, 26'(i), 32'hA000_0000 + 32'(i), st);
         if (st > worst) worst = st;
      end
      check(worst == 0, "R5 sequential low-order stream stalls", worst, 0);
      for (int i = 0; i < 16; i += 5) begin
         read_expect(0, 26'(i), 4'(i), 32'hA000_0000 + 32'(i), "R1 low-order read back");
      end
   endtask

   task automatic t_busy_bank_r4();
      int st;
      do_reset();
      issue(0, 1'b1, 26'h0000013, 32'h1111_2222, st);   // bank 3, offset 1
      issue(0, 1'b0, 26'h0000004, 32'h0, st);           // bank 4 while bank 3 busy
      check(st == 0, "R3 other bank unaffected by busy bank", st, 0);
      repeat (ACC - 1) @(negedge clk);
      do_reset();
      issue(0, 1'b1, 26'h0000013, 32'h1111_2222, st);
      issue(0, 1'b0, 26'h0000013, 32'h0, st);           // same bank again
      check(st == CYC - 1, "R4 stall cycles on busy bank", st, CYC - 1);
      repeat (ACC - 1) @(negedge clk);
      #1 check(rv_lo && rd_lo == 32'h1111_2222 && rb_lo == 4'd3, "R4 data after stall", rd_lo, 32'h1111_2222);
   endtask

   task automatic t_order_r7();
      int st;
      int quiet = 1;
      do_reset();
      issue(0, 1'b1, 26'h0000005, 32'h0000_0055, st);
      issue(0, 1'b1, 26'h0000006, 32'h0000_0066, st);
      issue(0, 1'b1, 26'h0000007, 32'h0000_0077, st);
      for (int i = 0; i < ACC + 1; i++) begin
         @(negedge clk); #1;
         if (rv_lo) quiet = 0;
      end
      check(quiet == 1, "R8 write produced a response", quiet, 1);
      @(negedge clk);
      issue(0, 1'b0, 26'h0000005, '0, st);
      issue(0, 1'b0, 26'h0000006, '0, st);
      issue(0, 1'b0, 26'h0000007, '0, st);
      check(st == 0, "R7 back-to-back reads stall", st, 0);
      repeat (ACC - 3) @(negedge clk);
      for (int i = 5; i < 8; i++) begin
         #1 check(rv_lo && rb_lo == 4'(i) && rd_lo == 32'(i * 17), "R7 response order",
                  {rb_lo, rd_lo}, {4'(i), 32'(i * 17)});
         @(negedge clk);
      end
   endtask

   task automatic t_high_r2();
      int st;
      do_reset();
      issue(1, 1'b1, 26'h1400003, 32'hBEEF_0005, st);   // bank 5, offset 3
      issue(1, 1'b1, 26'h0000001, 32'h0000_0001, st);   // bank 0
      issue(1, 1'b1, 26'h0000002, 32'h0000_0002, st);   // bank 0 again
      check(st == CYC - 1, "R2 adjacent addresses share a bank", st, CYC - 1);
      repeat (CYC) @(negedge clk);
      read_expect(1, 26'h1400003, 4'd5, 32'hBEEF_0005, "R2 high-order read");
      read_expect(1, 26'h0000003, 4'd0, 32'h0, "R2 other bank untouched");
   endtask

   task automatic t_eight_r10();
      int st;
      int worst = 0;
      do_reset();
      for (int i = 0; i < 9; i++) begin
         issue(2, 1'b1, 26'(i * 8 + i % 8 - (i / 8) * 8 * 1 + ((i == 8) ? 8 : 0) - ((i == 8) ? 8 : 0)), 32'h0, st);
         if (st > worst) worst = st;
      end
      check(worst == 0, "R10 return to bank after exactly the cycle time", worst, 0);
      issue(2, 1'b1, 26'd13, 32'h0000_D00D, st);
      repeat (CYC) @(negedge clk);
      read_expect(2, 26'd13, 4'd5, 32'h0000_D00D, "R10 eight-bank select");
   endtask

   initial begin
      t_reset_r9();
      t_low_stream_r5();
      t_busy_bank_r4();
      t_order_r7();
      t_high_r2();
      t_eight_r10();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule